// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block resolves a translation-cache miss for a 32-bit virtual address. It takes one walk request, reads one or two 32-bit translation descriptors from memory through a read port, and returns either a physical address with its attribute bits or a translation fault. The first fetch reads a first-level descriptor. Its two low type bits, and for mapped blocks one size bit, decide whether the walk ends there as a 1 MB section, a 16 MB supersection or a fault. If the descriptor points to a second-level table, a second fetch reads a small-page descriptor for a 4 KB page.

Every data path at the edge uses valid/ready. A request is taken only when `walk_valid` and `walk_ready` are both high on a rising edge. The walker holds `fetch_valid` and `fetch_addr` steady until `fetch_ready` accepts them. It raises `desc_ready` only while it waits for a descriptor. It holds the result steady on `res_valid` until `res_ready` takes it. `ttbase` is a plain input and is sampled together with the request. At most one walk is in flight, so `walk_ready` stays low from acceptance until the result is consumed.

Top module: `pw_top`

## Requirements
- R1: After reset, `walk_ready` is 1 and `fetch_valid`, `desc_ready` and `res_valid` are 0.
- R2: The first fetch address is `{ttbase[31:14], va[31:20], 2'b00}`, using the values sampled when the request is accepted.
- R3: A first-level descriptor whose bits [1:0] are 00 or 11 ends the walk after one fetch with `res_kind` = 0 (fault) and `res_l2_fault` = 0.
- R4: A first-level descriptor with bits [1:0] = 10 and bit 19 = 0 ends after one fetch with `res_kind` = 1 and PA `{d[31:20], va[19:0]}`.
- R5: A first-level descriptor with bits [1:0] = 10 and bit 19 = 1 ends after one fetch with `res_kind` = 2 and PA `{d[31:24], va[23:0]}`.
- R6: A first-level descriptor with bits [1:0] = 01 causes a second fetch at `{d1[31:10], va[19:12], 2'b00}`.
- R7: A second-level descriptor with bits [1:0] other than 00 gives `res_kind` = 3 and PA `{d2[31:12], va[11:0]}`.
- R8: A second-level descriptor with bits [1:0] = 00 gives `res_kind` = 0 and `res_l2_fault` = 1.
- R9: On success, `res_attr` equals bits [11:2] of the final descriptor. On a fault, `res_pa` and `res_attr` are zero.
- R10: A new request is taken only when no walk is in flight. At most one of `walk_ready`, `fetch_valid`, `desc_ready` and `res_valid` is high at any time.
- R11: While `res_valid` is high and `res_ready` is low, the result stays valid and unchanged.
- R12: While `fetch_valid` is high and `fetch_ready` is low, the fetch stays valid with an unchanged address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| walk_valid | input | 1 | Walk request valid |
| walk_ready | output | 1 | Walker idle, request can be taken |
| walk_va | input | 32 | Virtual address to translate |
| ttbase | input | 32 | First-level table base, sampled with the request |
| fetch_valid | output | 1 | Descriptor read request valid |
| fetch_ready | input | 1 | Memory accepts the read request |
| fetch_addr | output | 32 | Byte address of the descriptor |
| desc_valid | input | 1 | Descriptor data valid |
| desc_ready | output | 1 | Walker waiting for descriptor data |
| desc_data | input | 32 | Descriptor word |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_pa | output | 32 | Translated physical address |
| res_attr | output | 10 | Attribute bits from the final descriptor |
| res_kind | output | 2 | 0 fault, 1 section, 2 supersection, 3 small page |
| res_l2_fault | output | 1 | Fault raised at the second level |

## Verification
The bench builds the walker with its default geometry: a 32-bit address, a 12-bit first-level index, an 8-bit second-level index, a 12-bit page offset and 4 extra supersection bits. That geometry makes each descriptor type and both walk depths reachable with plain random words. It also lets the boundary addresses (all zeros and all ones, and table bases with junk in their low bits) expose any mistake in the slice positions. Random stall lengths on the fetch, descriptor and result handshakes exercise the back-pressure rules.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_DONE
  } walk_state_e;

  typedef enum logic [1:0] {
    KIND_FAULT = 2'd0, KIND_SECTION = 2'd1, KIND_SUPER = 2'd2, KIND_SMALL = 2'd3
  } walk_kind_e;

  localparam logic [1:0] DT_FAULT = 2'b00;
  localparam logic [1:0] DT_PTR   = 2'b01;
  localparam logic [1:0] DT_BLOCK = 2'b10;
endpackage

// File: rtl/pw_fsm.sv
module pw_fsm
  import pw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        walk_valid,
  input  logic        fetch_ready,
  input  logic        desc_valid,
  input  logic        l1_is_ptr,
  input  logic        res_ready,
  output walk_state_e state
);
  walk_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:    if (walk_valid)  nxt = S_L1_REQ;
      S_L1_REQ:  if (fetch_ready) nxt = S_L1_WAIT;
      S_L1_WAIT: if (desc_valid)  nxt = l1_is_ptr ? S_L2_REQ : S_DONE;
      S_L2_REQ:  if (fetch_ready) nxt = S_L2_WAIT;
      S_L2_WAIT: if (desc_valid)  nxt = S_DONE;
      S_DONE:    if (res_ready)   nxt = S_IDLE;
      default:                    nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
endmodule

// File: rtl/pw_addr.sv
module pw_addr #(
  parameter int ADDR_W    = 32,
  parameter int L1_IDX_W  = 12,
  parameter int L2_IDX_W  = 8,
  parameter int PG_OFF_W  = 12,
  localparam int SEC_OFF_W = L2_IDX_W + PG_OFF_W,
  localparam int L1_BASE_W = ADDR_W - L1_IDX_W - 2,
  localparam int L2_BASE_W = ADDR_W - L2_IDX_W - 2
) (
  input  logic                 use_l2,
  input  logic [ADDR_W-1:0]    va,
  input  logic [L1_BASE_W-1:0] l1_base,
  input  logic [L2_BASE_W-1:0] l2_base,
  output logic [ADDR_W-1:0]    addr
);
  always_comb begin
    if (use_l2) addr = {l2_base, va[PG_OFF_W +: L2_IDX_W], 2'b00};
    else        addr = {l1_base, va[SEC_OFF_W +: L1_IDX_W], 2'b00};
  end
endmodule

// File: rtl/pw_decode.sv
module pw_decode
  import pw_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int L2_IDX_W      = 8,
  parameter int PG_OFF_W      = 12,
  parameter int SUPER_EXTRA_W = 4,
  localparam int SEC_OFF_W = L2_IDX_W + PG_OFF_W,
  localparam int SUP_OFF_W = SEC_OFF_W + SUPER_EXTRA_W,
  localparam int ATTR_W    = PG_OFF_W - 2
) (
  input  logic              level2,
  input  logic [ADDR_W-1:0] desc,
  input  logic [ADDR_W-1:0] va,
  output walk_kind_e        kind,
  output logic [ADDR_W-1:0] pa,
  output logic [ATTR_W-1:0] attr,
  output logic              is_ptr,
  output logic              l2_fault
);
  always_comb begin
    kind     = KIND_FAULT;
    pa       = '0;
    attr     = '0;
    is_ptr   = 1'b0;
    l2_fault = 1'b0;
    if (level2) begin
      if (desc[1:0] == DT_FAULT) begin
        l2_fault = 1'b1;
      end else begin
        kind = KIND_SMALL;
        pa   = {desc[ADDR_W-1:PG_OFF_W], va[PG_OFF_W-1:0]};
        attr = desc[PG_OFF_W-1:2];
      end
    end else begin
      case (desc[1:0])
        DT_PTR: is_ptr = 1'b1;
        DT_BLOCK: begin
          attr = desc[PG_OFF_W-1:2];
          if (desc[SEC_OFF_W-1]) begin
            kind = KIND_SUPER;
            pa   = {desc[ADDR_W-1:SUP_OFF_W], va[SUP_OFF_W-1:0]};
          end else begin
            kind = KIND_SECTION;
            pa   = {desc[ADDR_W-1:SEC_OFF_W], va[SEC_OFF_W-1:0]};
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pw_top.sv
module pw_top
  import pw_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int L1_IDX_W      = 12,
  parameter int L2_IDX_W      = 8,
  parameter int PG_OFF_W      = 12,
  parameter int SUPER_EXTRA_W = 4,
  localparam int ATTR_W    = PG_OFF_W - 2,
  localparam int L1_BASE_W = ADDR_W - L1_IDX_W - 2,
  localparam int L2_BASE_W = ADDR_W - L2_IDX_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              walk_valid,
  output logic              walk_ready,
  input  logic [ADDR_W-1:0] walk_va,
  input  logic [ADDR_W-1:0] ttbase,
  output logic              fetch_valid,
  input  logic              fetch_ready,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [ADDR_W-1:0] desc_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [ADDR_W-1:0] res_pa,
  output logic [ATTR_W-1:0] res_attr,
  output logic [1:0]        res_kind,
  output logic              res_l2_fault
);
  walk_state_e           state;
  logic [ADDR_W-1:0]     va_q;
  logic [L1_BASE_W-1:0]  l1_base_q;
  logic [L2_BASE_W-1:0]  l2_base_q;
  logic [ADDR_W-1:0]     pa_q;
  logic [ATTR_W-1:0]     attr_q;
  logic [1:0]            kind_q;
  logic                  l2f_q;

  walk_kind_e            dec_kind;
  logic [ADDR_W-1:0]     dec_pa;
  logic [ATTR_W-1:0]     dec_attr;
  logic                  dec_ptr;
  logic                  dec_l2f;

  logic walk_fire, desc_fire, in_l2_wait;

  assign walk_ready  = (state == S_IDLE);
  assign fetch_valid = (state == S_L1_REQ) || (state == S_L2_REQ);
  assign desc_ready  = (state == S_L1_WAIT) || (state == S_L2_WAIT);
  assign res_valid   = (state == S_DONE);
  assign in_l2_wait  = (state == S_L2_WAIT);
  assign walk_fire   = walk_valid && walk_ready;
  assign desc_fire   = desc_valid && desc_ready;

  pw_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .walk_valid (walk_valid),
    .fetch_ready(fetch_ready),
    .desc_valid (desc_valid),
    .l1_is_ptr  (dec_ptr),
    .res_ready  (res_ready),
    .state      (state)
  );

  pw_addr #(
    .ADDR_W(ADDR_W), .L1_IDX_W(L1_IDX_W), .L2_IDX_W(L2_IDX_W), .PG_OFF_W(PG_OFF_W)
  ) u_addr (
    .use_l2 (state == S_L2_REQ),
    .va     (va_q),
    .l1_base(l1_base_q),
    .l2_base(l2_base_q),
    .addr   (fetch_addr)
  );

  pw_decode #(
    .ADDR_W(ADDR_W), .L2_IDX_W(L2_IDX_W), .PG_OFF_W(PG_OFF_W),
    .SUPER_EXTRA_W(SUPER_EXTRA_W)
  ) u_dec (
    .level2  (in_l2_wait),
    .desc    (desc_data),
    .va      (va_q),
    .kind    (dec_kind),
    .pa      (dec_pa),
    .attr    (dec_attr),
    .is_ptr  (dec_ptr),
    .l2_fault(dec_l2f)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q      <= '0;
      l1_base_q <= '0;
      l2_base_q <= '0;
      pa_q      <= '0;
      attr_q    <= '0;
      kind_q    <= KIND_FAULT;
      l2f_q     <= 1'b0;
    end else begin
      if (walk_fire) begin
        va_q      <= walk_va;
        l1_base_q <= ttbase[ADDR_W-1 -: L1_BASE_W];
      end
      if (desc_fire && !in_l2_wait)
        l2_base_q <= desc_data[ADDR_W-1 -: L2_BASE_W];
      if (desc_fire) begin
        pa_q   <= dec_pa;
        attr_q <= dec_attr;
        kind_q <= dec_kind;
        l2f_q  <= dec_l2f;
      end
    end
  end

  assign res_pa       = pa_q;
  assign res_attr     = attr_q;
  assign res_kind     = kind_q;
  assign res_l2_fault = l2f_q;
endmodule

// File: rtl/pw_checks.sv
module pw_checks #(
  parameter int ADDR_W = 32,
  parameter int ATTR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              walk_ready,
  input logic              fetch_valid,
  input logic              fetch_ready,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              desc_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic [ADDR_W-1:0] res_pa,
  input logic [ATTR_W-1:0] res_attr,
  input logic [1:0]        res_kind,
  input logic              res_l2_fault
);
  p_one_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({walk_ready, fetch_valid, desc_ready, res_valid}));

  p_fetch_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !fetch_ready |=> fetch_valid && $stable(fetch_addr));

  p_res_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_pa) && $stable(res_attr)
      && $stable(res_kind) && $stable(res_l2_fault));

  p_fault_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_kind == 2'd0 |-> res_pa == '0 && res_attr == '0);

  p_l2_fault_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_l2_fault |-> res_kind == 2'd0);

  p_word_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> fetch_addr[1:0] == 2'b00);
endmodule

bind pw_top pw_checks #(.ADDR_W(ADDR_W), .ATTR_W(ATTR_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .walk_ready(walk_ready), .fetch_valid(fetch_valid),
  .fetch_ready(fetch_ready), .fetch_addr(fetch_addr), .desc_ready(desc_ready),
  .res_valid(res_valid), .res_ready(res_ready), .res_pa(res_pa), .res_attr(res_attr),
  .res_kind(res_kind), .res_l2_fault(res_l2_fault)
);

// File: tb/tb_pw_top.sv
module tb_pw_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        walk_valid = 1'b0;
  logic        walk_ready;
  logic [31:0] walk_va = '0;
  logic [31:0] ttbase = '0;
  logic        fetch_valid;
  logic        fetch_ready = 1'b0;
  logic [31:0] fetch_addr;
  logic        desc_valid = 1'b0;
  logic        desc_ready;
  logic [31:0] desc_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [31:0] res_pa;
  logic [9:0]  res_attr;
  logic [1:0]  res_kind;
  logic        res_l2_fault;

  int n_checks = 0;
  int n_err = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  pw_top dut (.*);

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_checks++; n_err++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      report();
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic serve_fetch(input logic [31:0] exp_addr, input logic [31:0] data,
                             input string tag);
    int n = 0;
    logic [31:0] held;
    while (!fetch_valid && n < 50) begin @(negedge clk); n++; end
    chk(fetch_valid, tag, "fetch request", {31'd0, fetch_valid}, 32'd1);
    held = fetch_addr;
    repeat ($urandom % 3) begin
      @(negedge clk);
      chk(fetch_valid && fetch_addr == held, "R12", "stalled fetch", fetch_addr, held);
    end
    chk(fetch_addr == exp_addr, tag, "fetch address", fetch_addr, exp_addr);
    fetch_ready = 1'b1;
    @(negedge clk);
    fetch_ready = 1'b0;
    repeat ($urandom % 3) @(negedge clk);
    desc_data = data;
    desc_valid = 1'b1;
    n = 0;
    while (!desc_ready && n < 50) begin @(negedge clk); n++; end
    @(negedge clk);
    desc_valid = 1'b0;
    desc_data = $urandom;
  endtask

  task automatic do_walk(input logic [31:0] va, input logic [31:0] base,
                         input logic [31:0] d1, input logic [31:0] d2, input string tag);
    logic [31:0] epa = '0;
    logic [9:0]  eattr = '0;
    logic [1:0]  ekind = 2'd0;
    logic        el2f = 1'b0;
    bit          two = 1'b0;
    int          n = 0;
    case (d1[1:0])
      2'b10: begin
        eattr = d1[11:2];
        if (d1[19]) begin ekind = 2'd2; epa = {d1[31:24], va[23:0]}; end
        else        begin ekind = 2'd1; epa = {d1[31:20], va[19:0]}; end
      end
      2'b01: begin
        two = 1'b1;
        if (d2[1:0] == 2'b00) el2f = 1'b1;
        else begin ekind = 2'd3; epa = {d2[31:12], va[11:0]}; eattr = d2[11:2]; end
      end
      default: ;
    endcase

    walk_va = va; ttbase = base; walk_valid = 1'b1;
    while (!walk_ready && n < 50) begin @(negedge clk); n++; end
    @(negedge clk);
    walk_valid = 1'b0; walk_va = $urandom; ttbase = $urandom;
    chk(!walk_ready, "R10", "ready while busy", {31'd0, walk_ready}, 32'd0);

    serve_fetch({base[31:14], va[31:20], 2'b00}, d1, "R2");
    if (two) serve_fetch({d1[31:10], va[19:12], 2'b00}, d2, "R6");

    n = 0;
    while (!res_valid && n < 50) begin @(negedge clk); n++; end
    chk(!fetch_valid, two ? "R6" : "R3", "no extra fetch", {31'd0, fetch_valid}, 32'd0);
    chk(!walk_ready, "R10", "ready at result", {31'd0, walk_ready}, 32'd0);
    repeat ($urandom % 3) @(negedge clk);
    chk(res_valid, "R11", "result held", {31'd0, res_valid}, 32'd1);
    chk(res_kind == ekind, tag, "kind", {30'd0, res_kind}, {30'd0, ekind});
    chk(res_pa == epa, tag, "pa", res_pa, epa);
    chk(res_attr == eattr, "R9", "attr", {22'd0, res_attr}, {22'd0, eattr});
    chk(res_l2_fault == el2f, two ? "R8" : "R3", "level flag",
        {31'd0, res_l2_fault}, {31'd0, el2f});
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(walk_ready && !res_valid, "R10", "idle after result", {31'd0, walk_ready}, 32'd1);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk(walk_ready && !fetch_valid && !desc_ready && !res_valid, "R1", "reset state",
        {28'd0, walk_ready, fetch_valid, desc_ready, res_valid}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(walk_ready && !fetch_valid && !desc_ready && !res_valid, "R1", "after reset",
        {28'd0, walk_ready, fetch_valid, desc_ready, res_valid}, 32'h8);

    do_walk(32'h0000_0000, 32'h0000_3FFF, 32'hFFFF_FFFC, 32'h0, "R3");
    do_walk(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1234_5673, 32'h0, "R3");
    do_walk(32'hFFFF_FFFF, 32'hABCD_C000, 32'hABC7_FFFE, 32'h0, "R4");
    do_walk(32'h0000_0000, 32'h0000_0000, 32'h5A08_0AAA, 32'h0, "R5");
    do_walk(32'hFFFF_FFFF, 32'h8000_4000, 32'h9876_5401, 32'hCAFE_F55E, "R7");
    do_walk(32'h0123_4567, 32'h1111_1111, 32'h0000_0401, 32'hFFFF_FFFC, "R8");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] d1 = $urandom;
      logic [31:0] d2 = $urandom;
      string t;
      case (d1[1:0])
        2'b10:   t = d1[19] ? "R5" : "R4";
        2'b01:   t = (d2[1:0] == 2'b00) ? "R8" : "R7";
        default: t = "R3";
      endcase
      do_walk($urandom, $urandom, d1, d2, t);
    end
    report();
  end
endmodule